// File: doc/BRIEF.md
# Sequential Next-Line Prefetch Generator

This block sits beside a cache and turns one trigger address, usually a miss, into a short run of prefetch candidates for the cache lines that follow it. The trigger is first rounded down to its line boundary. The block then offers the next `cfg_degree` line addresses, one candidate per handshake and in ascending order, on a valid/ready output. Every candidate carries the same issue-delay tag.

When page-stop is on, the block checks each candidate against the page that holds the aligned trigger. The first candidate that falls outside that page ends the run. That candidate and every later one in the run are counted into a saturating dropped-candidate counter and are not emitted. Line size, page size, run length, page-stop and delay are configuration inputs. The block captures them when it accepts a trigger, so a run always finishes under the settings it started with.

Top module: `nlpf_gen`

## Requirements
- R1: The first candidate of a run equals the trigger address with its low `cfg_line_lg2` bits cleared, plus 2^`cfg_line_lg2`.
- R2: Candidate d (1 ≤ d ≤ `cfg_degree`) equals the aligned trigger plus d·2^`cfg_line_lg2`, modulo 2^AW. Candidates leave in ascending d, one per cycle in which `pf_valid` and `pf_ready` are both high.
- R3: With `cfg_page_stop`=1, the run ends at the first candidate whose bits above `cfg_page_lg2` differ from those of the aligned trigger. That candidate and all later ones are never presented.
- R4: A page stop at candidate d adds `cfg_degree` − d + 1 to `drop_count`. `drop_count` changes at no other time.
- R5: With `cfg_page_stop`=0, all `cfg_degree` candidates are emitted, including those past a page boundary.
- R6: `pf_delay` equals the `cfg_latency` value captured with the trigger, for every candidate.
- R7: `trig_ready` is low while a run is active. A trigger offered then is ignored, and the run's candidates are unchanged.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid`, `pf_addr` and `pf_delay` hold their values into the next cycle.
- R9: A trigger accepted with `cfg_degree`=0 produces no candidate and leaves `drop_count` unchanged.
- R10: `drop_count` is CNT_W bits wide (32 by default), never decreases, and saturates at all ones.
- R11: After synchronous reset `pf_valid` is 0, `trig_ready` is 1 and `drop_count` is 0.
- R12: A change to any configuration input after the trigger is accepted does not affect the candidates or the delay tag of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_degree | input | DEG_W | Number of candidates per run |
| cfg_line_lg2 | input | LGW | log2 of line size in bytes |
| cfg_page_lg2 | input | LGW | log2 of page size in bytes |
| cfg_page_stop | input | 1 | 1 = end the run at the trigger's page boundary |
| cfg_latency | input | LAT_W | Delay tag attached to every candidate |
| trig_valid | input | 1 | Trigger address offered |
| trig_ready | output | 1 | Generator idle and able to take a trigger |
| trig_addr | input | AW | Trigger (miss/access) address |
| pf_valid | output | 1 | Candidate presented |
| pf_ready | input | 1 | Consumer takes the candidate |
| pf_addr | output | AW | Candidate line address |
| pf_delay | output | LAT_W | Issue-delay tag of the candidate |
| drop_count | output | CNT_W | Saturating count of candidates dropped at page stops |

## Verification
The assertions take for granted that line size never exceeds page size (`cfg_line_lg2` ≤ `cfg_page_lg2` < AW), and that `cfg_degree` fits in the counter width. Under those conditions the aligned trigger and the raw trigger share a page, which is what lets the page check be written against the raw trigger address. The bench keeps every applied configuration inside those bounds. It changes the configuration only while a run is busy, or in the cycle before a trigger it is about to offer. Trigger addresses include offsets near a page end and one near the top of the address space, so both page stops and address wraparound occur.

// File: rtl/nlpf_pkg.sv
package nlpf_pkg;

  typedef enum logic {
    NLPF_IDLE  = 1'b0,
    NLPF_BURST = 1'b1
  } nlpf_state_e;

endpackage

// File: rtl/nlpf_next_addr.sv
// Computes the line that follows a base address and decides whether that
// line leaves the reference page (only when page-stop is enabled).
module nlpf_next_addr #(
  parameter int AW  = 32,
  parameter int LGW = 5
) (
  input  logic [AW-1:0]  base_addr,
  input  logic [LGW-1:0] line_lg2,
  input  logic [LGW-1:0] page_lg2,
  input  logic [AW-1:0]  ref_page,
  input  logic           page_stop,
  output logic [AW-1:0]  next_addr,
  output logic           leaves_page
);

  logic [AW-1:0] line_bytes;
  logic [AW-1:0] page_hi_mask;

  always_comb begin
    line_bytes   = AW'(1) << line_lg2;
    page_hi_mask = ~((AW'(1) << page_lg2) - AW'(1));
    next_addr    = base_addr + line_bytes;
    leaves_page  = page_stop && ((next_addr & page_hi_mask) != ref_page);
  end

endmodule

// File: rtl/nlpf_drop_ctr.sv
// Saturating accumulator for candidates suppressed at page stops.
module nlpf_drop_ctr #(
  parameter int CNT_W = 32,
  parameter int DEG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [DEG_W-1:0] add_val,
  output logic [CNT_W-1:0] count
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, count} + SUM_W'(add_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (add_en) begin
      if (sum[CNT_W]) begin
        count <= '1;
      end else begin
        count <= sum[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/nlpf_seq.sv
// Run sequencer: captures trigger and configuration, steps through the
// candidate lines, and reports how many candidates a page stop discards.
module nlpf_seq #(
  parameter int AW    = 32,
  parameter int LGW   = 5,
  parameter int DEG_W = 4,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEG_W-1:0] cfg_degree,
  input  logic [LGW-1:0]   cfg_line_lg2,
  input  logic [LGW-1:0]   cfg_page_lg2,
  input  logic             cfg_page_stop,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic             trig_valid,
  input  logic [AW-1:0]    trig_addr,
  input  logic             pf_ready,
  output logic             busy,
  output logic [AW-1:0]    cand_addr,
  output logic [LAT_W-1:0] cand_delay,
  output logic             drop_en,
  output logic [DEG_W-1:0] drop_val
);

  import nlpf_pkg::*;

  nlpf_state_e      state_q;
  logic [AW-1:0]    cur_q;
  logic [DEG_W-1:0] idx_q;
  logic [DEG_W-1:0] deg_q;
  logic [LGW-1:0]   line_lg2_q;
  logic [LGW-1:0]   page_lg2_q;
  logic             stop_q;
  logic [LAT_W-1:0] lat_q;
  logic [AW-1:0]    page_q;

  logic [AW-1:0]    trig_aligned;
  logic [AW-1:0]    trig_page;
  logic             accept;
  logic             advance;
  logic             last_cand;

  logic [AW-1:0]    step_base;
  logic [LGW-1:0]   step_line;
  logic [LGW-1:0]   step_page_lg2;
  logic [AW-1:0]    step_ref_page;
  logic             step_stop;
  logic [AW-1:0]    step_next;
  logic             step_leaves;

  always_comb begin
    trig_aligned = trig_addr & ~((AW'(1) << cfg_line_lg2) - AW'(1));
    trig_page    = trig_aligned & ~((AW'(1) << cfg_page_lg2) - AW'(1));
    accept       = trig_valid && (state_q == NLPF_IDLE);
    advance      = (state_q == NLPF_BURST) && pf_ready;
    last_cand    = (idx_q == deg_q);
  end

  // One stepping unit, shared between run start and run progress.
  always_comb begin
    if (state_q == NLPF_BURST) begin
      step_base     = cur_q;
      step_line     = line_lg2_q;
      step_page_lg2 = page_lg2_q;
      step_ref_page = page_q;
      step_stop     = stop_q;
    end else begin
      step_base     = trig_aligned;
      step_line     = cfg_line_lg2;
      step_page_lg2 = cfg_page_lg2;
      step_ref_page = trig_page;
      step_stop     = cfg_page_stop;
    end
  end

  nlpf_next_addr #(
    .AW  (AW),
    .LGW (LGW)
  ) u_step (
    .base_addr   (step_base),
    .line_lg2    (step_line),
    .page_lg2    (step_page_lg2),
    .ref_page    (step_ref_page),
    .page_stop   (step_stop),
    .next_addr   (step_next),
    .leaves_page (step_leaves)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= NLPF_IDLE;
      cur_q      <= '0;
      idx_q      <= '0;
      deg_q      <= '0;
      line_lg2_q <= '0;
      page_lg2_q <= '0;
      stop_q     <= 1'b0;
      lat_q      <= '0;
      page_q     <= '0;
    end else if (accept) begin
      deg_q      <= cfg_degree;
      line_lg2_q <= cfg_line_lg2;
      page_lg2_q <= cfg_page_lg2;
      stop_q     <= cfg_page_stop;
      lat_q      <= cfg_latency;
      page_q     <= trig_page;
      cur_q      <= step_next;
      idx_q      <= DEG_W'(1);
      if ((cfg_degree != '0) && !step_leaves) begin
        state_q <= NLPF_BURST;
      end
    end else if (advance) begin
      if (last_cand || step_leaves) begin
        state_q <= NLPF_IDLE;
      end else begin
        cur_q <= step_next;
        idx_q <= idx_q + DEG_W'(1);
      end
    end
  end

  // Candidate count discarded by a page stop: at run start every candidate
  // goes; mid-run the ones from index idx+1 to the end go.
  always_comb begin
    drop_en  = 1'b0;
    drop_val = '0;
    if (accept && (cfg_degree != '0) && step_leaves) begin
      drop_en  = 1'b1;
      drop_val = cfg_degree;
    end else if (advance && !last_cand && step_leaves) begin
      drop_en  = 1'b1;
      drop_val = deg_q - idx_q;
    end
  end

  always_comb begin
    busy       = (state_q == NLPF_BURST);
    cand_addr  = cur_q;
    cand_delay = lat_q;
  end

endmodule

// File: rtl/nlpf_gen.sv
module nlpf_gen #(
  parameter int AW    = 32,
  parameter int LGW   = 5,
  parameter int DEG_W = 4,
  parameter int LAT_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEG_W-1:0] cfg_degree,
  input  logic [LGW-1:0]   cfg_line_lg2,
  input  logic [LGW-1:0]   cfg_page_lg2,
  input  logic             cfg_page_stop,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic             trig_valid,
  output logic             trig_ready,
  input  logic [AW-1:0]    trig_addr,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [AW-1:0]    pf_addr,
  output logic [LAT_W-1:0] pf_delay,
  output logic [CNT_W-1:0] drop_count
);

  logic             busy;
  logic             drop_en;
  logic [DEG_W-1:0] drop_val;

  nlpf_seq #(
    .AW    (AW),
    .LGW   (LGW),
    .DEG_W (DEG_W),
    .LAT_W (LAT_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cfg_degree    (cfg_degree),
    .cfg_line_lg2  (cfg_line_lg2),
    .cfg_page_lg2  (cfg_page_lg2),
    .cfg_page_stop (cfg_page_stop),
    .cfg_latency   (cfg_latency),
    .trig_valid    (trig_valid),
    .trig_addr     (trig_addr),
    .pf_ready      (pf_ready),
    .busy          (busy),
    .cand_addr     (pf_addr),
    .cand_delay    (pf_delay),
    .drop_en       (drop_en),
    .drop_val      (drop_val)
  );

  nlpf_drop_ctr #(
    .CNT_W (CNT_W),
    .DEG_W (DEG_W)
  ) u_drop (
    .clk     (clk),
    .rst     (rst),
    .add_en  (drop_en),
    .add_val (drop_val),
    .count   (drop_count)
  );

  assign pf_valid   = busy;
  assign trig_ready = ~busy;

endmodule

// File: rtl/nlpf_gen_chk.sv
module nlpf_gen_chk #(
  parameter int AW    = 32,
  parameter int LGW   = 5,
  parameter int DEG_W = 4,
  parameter int LAT_W = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [DEG_W-1:0] cfg_degree,
  input logic [LGW-1:0]   cfg_line_lg2,
  input logic [LGW-1:0]   cfg_page_lg2,
  input logic             cfg_page_stop,
  input logic [LAT_W-1:0] cfg_latency,
  input logic             trig_valid,
  input logic             trig_ready,
  input logic [AW-1:0]    trig_addr,
  input logic             pf_valid,
  input logic             pf_ready,
  input logic [AW-1:0]    pf_addr,
  input logic [LAT_W-1:0] pf_delay,
  input logic [CNT_W-1:0] drop_count
);

  logic          take;
  logic [AW-1:0] first_exp;

  always_comb begin
    take      = trig_valid && trig_ready;
    first_exp = (trig_addr & ~((AW'(1) << cfg_line_lg2) - AW'(1)))
              + (AW'(1) << cfg_line_lg2);
  end

  a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pf_valid && trig_ready && (drop_count == '0)));

  a_r7_busy_blocks_trigger: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !trig_ready);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr) && $stable(pf_delay)));

  a_r6_delay_steady: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && $past(pf_valid)) |-> (pf_delay == $past(pf_delay)));

  a_r6_delay_captured: assert property (@(posedge clk) disable iff (rst)
    take |=> (!pf_valid || (pf_delay == $past(cfg_latency))));

  a_r1_first_line: assert property (@(posedge clk) disable iff (rst)
    take |=> (!pf_valid || (pf_addr == $past(first_exp))));

  a_r3_same_page: assert property (@(posedge clk) disable iff (rst)
    (take && cfg_page_stop) |=>
      (!pf_valid || (((pf_addr ^ $past(trig_addr)) >> $past(cfg_page_lg2)) == '0)));

  a_r9_zero_degree: assert property (@(posedge clk) disable iff (rst)
    (take && (cfg_degree == '0)) |=> (!pf_valid && $stable(drop_count)));

  a_r10_no_decrease: assert property (@(posedge clk) disable iff (rst)
    pf_ready || !pf_ready |=> (drop_count >= $past(drop_count)));

endmodule

bind nlpf_gen nlpf_gen_chk #(
  .AW    (AW),
  .LGW   (LGW),
  .DEG_W (DEG_W),
  .LAT_W (LAT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_degree    (cfg_degree),
  .cfg_line_lg2  (cfg_line_lg2),
  .cfg_page_lg2  (cfg_page_lg2),
  .cfg_page_stop (cfg_page_stop),
  .cfg_latency   (cfg_latency),
  .trig_valid    (trig_valid),
  .trig_ready    (trig_ready),
  .trig_addr     (trig_addr),
  .pf_valid      (pf_valid),
  .pf_ready      (pf_ready),
  .pf_addr       (pf_addr),
  .pf_delay      (pf_delay),
  .drop_count    (drop_count)
);

// File: tb/nlpf_gen_bench.sv
`timescale 1ns/1ps
module nlpf_gen_bench;

  localparam int AW    = 32;
  localparam int LGW   = 5;
  localparam int DEG_W = 4;
  localparam int LAT_W = 8;
  localparam int CNT_W = 32;
  localparam int SMALL_CNT_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic [DEG_W-1:0] cfg_degree;
  logic [LGW-1:0]   cfg_line_lg2;
  logic [LGW-1:0]   cfg_page_lg2;
  logic             cfg_page_stop;
  logic [LAT_W-1:0] cfg_latency;
  logic             trig_valid;
  logic             trig_ready;
  logic [AW-1:0]    trig_addr;
  logic             pf_valid;
  logic             pf_ready;
  logic [AW-1:0]    pf_addr;
  logic [LAT_W-1:0] pf_delay;
  logic [CNT_W-1:0] drop_count;

  logic                   s_trig_valid;
  logic                   s_trig_ready;
  logic                   s_pf_valid;
  logic [AW-1:0]          s_pf_addr;
  logic [LAT_W-1:0]       s_pf_delay;
  logic [SMALL_CNT_W-1:0] s_drop_count;

  nlpf_gen #(.AW(AW), .LGW(LGW), .DEG_W(DEG_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) u_nlpf_gen (
    .clk(clk), .rst(rst), .cfg_degree(cfg_degree), .cfg_line_lg2(cfg_line_lg2),
    .cfg_page_lg2(cfg_page_lg2), .cfg_page_stop(cfg_page_stop), .cfg_latency(cfg_latency),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_addr(trig_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_delay(pf_delay),
    .drop_count(drop_count)
  );

  // Narrow-counter copy used only to reach saturation quickly.
  nlpf_gen #(.AW(AW), .LGW(LGW), .DEG_W(DEG_W), .LAT_W(LAT_W), .CNT_W(SMALL_CNT_W)) u_nlpf_gen_sat (
    .clk(clk), .rst(rst), .cfg_degree(4'd7), .cfg_line_lg2(5'd4),
    .cfg_page_lg2(5'd6), .cfg_page_stop(1'b1), .cfg_latency(8'd1),
    .trig_valid(s_trig_valid), .trig_ready(s_trig_ready), .trig_addr(32'h0000_0030),
    .pf_valid(s_pf_valid), .pf_ready(1'b1), .pf_addr(s_pf_addr), .pf_delay(s_pf_delay),
    .drop_count(s_drop_count)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_drop = '0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [31:0] addr, input int deg, input int llg,
                           input int plg, input bit ps, input logic [7:0] lat);
    logic [31:0] exp_a [16];
    int          ne;
    int          dropinc;
    logic [31:0] al;
    logic [31:0] c;
    int          n;
    int          guard;
    bit          prev_stall;
    logic [31:0] prev_addr;
    bit          rdy;
    bit          crossed;
    al = addr & ~((32'd1 << llg) - 32'd1);
    ne = 0;
    dropinc = 0;
    crossed = 1'b0;
    for (int d = 1; d <= deg; d++) begin
      c = al + 32'(d) * (32'd1 << llg);
      if (ps && ((c >> plg) != (al >> plg))) begin
        dropinc = deg - d + 1;
        crossed = 1'b1;
        break;
      end
      exp_a[ne] = c;
      ne++;
    end
    @(negedge clk);
    cfg_degree    = DEG_W'(deg);
    cfg_line_lg2  = LGW'(llg);
    cfg_page_lg2  = LGW'(plg);
    cfg_page_stop = ps;
    cfg_latency   = lat;
    trig_addr     = addr;
    trig_valid    = 1'b1;
    pf_ready      = 1'b0;
    check(trig_ready == 1'b1, "R7", "idle trig_ready", 64'(trig_ready), 64'd1);
    @(negedge clk);
    trig_valid = 1'b0;
    // R12: scramble configuration after acceptance
    cfg_latency   = ~lat;
    cfg_line_lg2  = LGW'(llg + 1);
    cfg_degree    = DEG_W'(deg + 3);
    cfg_page_stop = ~ps;
    n = 0;
    guard = 0;
    prev_stall = 1'b0;
    prev_addr = '0;
    while (pf_valid && guard < 200) begin
      check(!trig_ready, "R7", "trig_ready during run", 64'(trig_ready), 64'd0);
      if (prev_stall)
        check(pf_addr == prev_addr, "R8", "held address", 64'(pf_addr), 64'(prev_addr));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = lfsr[0] | lfsr[1];
      if (rdy) begin
        if (n < ne) begin
          check(pf_addr == exp_a[n], (n == 0) ? "R1" : "R2", "candidate address",
                64'(pf_addr), 64'(exp_a[n]));
        end else begin
          check(1'b0, "R2", "extra candidate", 64'(pf_addr), 64'(n));
        end
        check(pf_delay == lat, "R6 R12", "delay tag", 64'(pf_delay), 64'(lat));
        n++;
      end
      prev_stall = !rdy;
      prev_addr  = pf_addr;
      pf_ready   = rdy;
      trig_valid = 1'b1;
      trig_addr  = 32'hDEAD_BEEF;
      @(negedge clk);
      guard++;
    end
    trig_valid = 1'b0;
    pf_ready   = 1'b0;
    if (deg == 0)
      check(n == 0, "R9", "count for zero degree", 64'(n), 64'd0);
    else if (ps)
      check(n == ne, "R3", "emitted count with page stop", 64'(n), 64'(ne));
    else
      check(n == ne, "R5", "emitted count without page stop", 64'(n), 64'(ne));
    exp_drop = exp_drop + 32'(dropinc);
    check(drop_count == exp_drop, crossed ? "R4" : "R9 R4", "drop counter",
          64'(drop_count), 64'(exp_drop));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] addrs [4];
    int lg_pages [2];
    int exp_s;
    addrs[0] = 32'h1000_0003;
    addrs[1] = 32'h1000_0027;
    addrs[2] = 32'h1000_00F5;
    addrs[3] = 32'hFFFF_FFF9;
    lg_pages[0] = 6;
    lg_pages[1] = 8;
    rst = 1'b1;
    cfg_degree = '0; cfg_line_lg2 = 5'd4; cfg_page_lg2 = 5'd6;
    cfg_page_stop = 1'b0; cfg_latency = '0;
    trig_valid = 1'b0; trig_addr = '0; pf_ready = 1'b0;
    s_trig_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pf_valid == 1'b0, "R11", "pf_valid after reset", 64'(pf_valid), 64'd0);
    check(trig_ready == 1'b1, "R11", "trig_ready after reset", 64'(trig_ready), 64'd1);
    check(drop_count == '0, "R11", "drop_count after reset", 64'(drop_count), 64'd0);
    check(s_drop_count == '0, "R11", "narrow drop_count after reset", 64'(s_drop_count), 64'd0);

    for (int li = 2; li <= 4; li++)
      for (int pi = 0; pi < 2; pi++)
        for (int dg = 0; dg <= 7; dg++)
          for (int ps = 0; ps < 2; ps++)
            for (int ai = 0; ai < 4; ai++)
              run_burst(addrs[ai], dg, li, lg_pages[pi], ps[0], 8'(dg * 16 + ai + li));

    // R10: narrow counter gains 7 per trigger and must clamp at 15
    exp_s = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      s_trig_valid = 1'b1;
      @(negedge clk);
      s_trig_valid = 1'b0;
      exp_s = (exp_s + 7 > 15) ? 15 : exp_s + 7;
      check(s_drop_count == SMALL_CNT_W'(exp_s), "R10", "saturating counter",
            64'(s_drop_count), 64'(exp_s));
      check(s_pf_valid == 1'b0, "R3", "narrow unit emits nothing", 64'(s_pf_valid), 64'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule